// File: doc/BRIEF.md
# Two-Stage Page-Table Entry Accessed/Dirty Updater

This block is used during a two-stage address translation walk, once a page-table entry has been fetched. It decides whether the entry's accessed (A) and dirty (D) bits must change for the current access. If they must, it either reports the fault that the active update enables call for, or it issues one atomic compare-and-swap of the patched entry to memory. The walker gives it the fetched entry and its address, the stage the entry belongs to (first stage or G-stage), the access type, the two hardware update enables and, for a first-stage entry, the write permission of the G-stage entry that maps it.

Each accepted request ends in exactly one single-cycle result pulse. The possible results are done, retry the walk from the entry fetch, page fault, guest page fault or access fault. The walker treats a G-stage lookup made on behalf of a first-stage table fetch as an implicit access. It presents that access as a read with the implicit flag set, and the flag only changes the G-stage update rule. While the block is idle it accepts a new request through a valid/ready pair. The memory side uses a valid/ready request and a response that carries a compare-match flag and a protection-error flag.

Top module: `ad_updater`

## Requirements
- R1: After reset, req_ready_o is 1, mem_valid_o is 0 and all five result pulses are 0.
- R2: For a G-stage entry with A=1, no memory access is issued and done_o pulses when D=1, or the access is not a store and the implicit rule of R3 does not apply.
- R3: A G-stage implicit access to an entry with D=0 and W=1 requires an update that sets D, but only when both fs_upd_en_i and gs_upd_en_i are 1. If either enable is 0, that entry with A=1 is left alone and done_o pulses.
- R4: A G-stage entry that needs an update (A=0, a store with D=0, or R3) while gs_upd_en_i is 0 produces gpf_o with no memory access.
- R5: A first-stage entry needs no update, and done_o pulses with no memory access, when A=1 and either D=1, the access is not a store, or W=0.
- R6: A first-stage entry that needs an update while gs_pte_w_i is 0 produces gpf_o, whatever fs_upd_en_i is.
- R7: A first-stage entry that needs an update, with gs_pte_w_i=1 and fs_upd_en_i=0, produces pf_o.
- R8: An update issues one compare-and-swap to the entry address. The compare value is the fetched entry. The write value is that entry with A (bit 6) set and D (bit 7) set for a store or for the R3 case, and every other bit unchanged. W is bit 2.
- R9: A memory response with the error flag produces af_o, whatever the match flag is.
- R10: A response without error: if the match flag is set, done_o pulses; if it is clear, retry_o pulses.
- R11: Each accepted request produces exactly one result pulse, one cycle long.
- R12: flt_type_o is valid with pf_o, gpf_o and af_o. It is 2 for an execute, otherwise 1 for a store, otherwise 0 (read or implicit).
- R13: req_ready_o is 0 from the cycle after a request is accepted until its result pulse, including while the memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_pte_i | input | PTE_W | Fetched page-table entry |
| req_addr_i | input | ADDR_W | Address of that entry |
| req_gstage_i | input | 1 | 1 = G-stage entry, 0 = first-stage entry |
| acc_write_i | input | 1 | Original access is a store |
| acc_exec_i | input | 1 | Original access is an execute |
| acc_implicit_i | input | 1 | Implicit walk access (read) |
| fs_upd_en_i | input | 1 | First-stage hardware A/D update enable |
| gs_upd_en_i | input | 1 | G-stage hardware A/D update enable |
| gs_pte_w_i | input | 1 | W of the G-stage entry mapping a first-stage entry |
| mem_valid_o | output | 1 | Compare-and-swap request |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_addr_o | output | ADDR_W | Entry address |
| mem_cmp_o | output | PTE_W | Compare value |
| mem_wdata_o | output | PTE_W | Swap value |
| mem_rsp_valid_i | input | 1 | Response present |
| mem_rsp_match_i | input | 1 | Memory held the compare value, swap done |
| mem_rsp_err_i | input | 1 | Store failed an attribute or protection check |
| done_o | output | 1 | Result: finished |
| retry_o | output | 1 | Result: refetch entry and retry |
| pf_o | output | 1 | Result: page fault |
| gpf_o | output | 1 | Result: guest page fault |
| af_o | output | 1 | Result: access fault |
| flt_type_o | output | 2 | Fault access type: 0 read, 1 store, 2 execute |

## Verification
The bench builds the block with a 16-bit entry and a 12-bit address, and keeps the flag positions at bits 2, 6 and 7. The narrow entry lets the bits above the flags carry a pattern that changes per case, so any corruption of untouched bits shows in the swap value. The sweep covers every combination of stage, A, D, W, the four access kinds, both enables and the G-stage write permission. Each combination that needs an update receives a matching, a mismatching or an erroring response in rotation, so every fault priority and response outcome is reached.

// File: rtl/ad_pkg.sv
package ad_pkg;
  typedef enum logic [1:0] {
    OUT_DONE   = 2'd0,
    OUT_UPDATE = 2'd1,
    OUT_PF     = 2'd2,
    OUT_GPF    = 2'd3
  } ad_outcome_e;

  typedef enum logic [1:0] {
    FT_LOAD  = 2'd0,
    FT_STORE = 2'd1,
    FT_FETCH = 2'd2
  } ad_ftype_e;
endpackage

// File: rtl/ad_decide.sv
module ad_decide
  import ad_pkg::*;
(
  input  logic        gstage_i,
  input  logic        a_i,
  input  logic        d_i,
  input  logic        w_i,
  input  logic        wr_i,
  input  logic        ex_i,
  input  logic        imp_i,
  input  logic        fs_en_i,
  input  logic        gs_en_i,
  input  logic        gs_w_i,
  output ad_outcome_e outcome_o,
  output logic        set_d_o,
  output ad_ftype_e   ftype_o
);
  logic force_d, gs_need, fs_need;

  // implicit G-stage access pre-sets D so it never needs revisiting later
  assign force_d = imp_i & ~d_i & w_i & fs_en_i & gs_en_i;
  assign gs_need = ~a_i | (wr_i & ~d_i) | force_d;
  assign fs_need = ~a_i | (wr_i & ~d_i & w_i);

  always_comb begin
    outcome_o = OUT_DONE;
    set_d_o   = wr_i;
    if (gstage_i) begin
      set_d_o = wr_i | force_d;
      if (gs_need) outcome_o = gs_en_i ? OUT_UPDATE : OUT_GPF;
    end else if (fs_need) begin
      if (!gs_w_i)       outcome_o = OUT_GPF;
      else if (!fs_en_i) outcome_o = OUT_PF;
      else               outcome_o = OUT_UPDATE;
    end
  end

  always_comb begin
    if (ex_i)      ftype_o = FT_FETCH;
    else if (wr_i) ftype_o = FT_STORE;
    else           ftype_o = FT_LOAD;
  end
endmodule

// File: rtl/ad_pte_patch.sv
module ad_pte_patch #(
  parameter int PTE_W = 64,
  parameter int A_BIT = 6,
  parameter int D_BIT = 7
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             set_d_i,
  output logic [PTE_W-1:0] pte_o
);
  for (genvar b = 0; b < PTE_W; b++) begin : g_bit
    if (b == A_BIT) begin : g_a
      assign pte_o[b] = 1'b1;
    end else if (b == D_BIT) begin : g_d
      assign pte_o[b] = pte_i[b] | set_d_i;
    end else begin : g_keep
      assign pte_o[b] = pte_i[b];
    end
  end
endmodule

// File: rtl/ad_ctrl.sv
module ad_ctrl
  import ad_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  ad_outcome_e outcome_i,
  input  logic        mem_ready_i,
  input  logic        rsp_valid_i,
  input  logic        rsp_match_i,
  input  logic        rsp_err_i,
  output logic        idle_o,
  output logic        mem_valid_o,
  output logic        done_o,
  output logic        retry_o,
  output logic        pf_o,
  output logic        gpf_o,
  output logic        af_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_ISSUE, ST_WAIT} st_e;
  st_e st_q;

  assign idle_o      = (st_q == ST_IDLE);
  assign mem_valid_o = (st_q == ST_ISSUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      done_o  <= 1'b0;
      retry_o <= 1'b0;
      pf_o    <= 1'b0;
      gpf_o   <= 1'b0;
      af_o    <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      retry_o <= 1'b0;
      pf_o    <= 1'b0;
      gpf_o   <= 1'b0;
      af_o    <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_EVAL;
        ST_EVAL: begin
          st_q <= ST_IDLE;
          unique case (outcome_i)
            OUT_DONE:   done_o <= 1'b1;
            OUT_PF:     pf_o   <= 1'b1;
            OUT_GPF:    gpf_o  <= 1'b1;
            OUT_UPDATE: st_q   <= ST_ISSUE;
            default:    st_q   <= ST_IDLE;
          endcase
        end
        ST_ISSUE: if (mem_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          st_q <= ST_IDLE;
          if (rsp_err_i)        af_o    <= 1'b1;
          else if (rsp_match_i) done_o  <= 1'b1;
          else                  retry_o <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ad_updater.sv
module ad_updater
  import ad_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 56,
  parameter int W_BIT  = 2,
  parameter int A_BIT  = 6,
  parameter int D_BIT  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [PTE_W-1:0]  req_pte_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_gstage_i,
  input  logic              acc_write_i,
  input  logic              acc_exec_i,
  input  logic              acc_implicit_i,
  input  logic              fs_upd_en_i,
  input  logic              gs_upd_en_i,
  input  logic              gs_pte_w_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PTE_W-1:0]  mem_cmp_o,
  output logic [PTE_W-1:0]  mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_rsp_match_i,
  input  logic              mem_rsp_err_i,
  output logic              done_o,
  output logic              retry_o,
  output logic              pf_o,
  output logic              gpf_o,
  output logic              af_o,
  output logic [1:0]        flt_type_o
);
  logic [PTE_W-1:0]  pte_q;
  logic [ADDR_W-1:0] addr_q;
  logic gstage_q, wr_q, ex_q, imp_q, fs_en_q, gs_en_q, gs_w_q;
  logic start, set_d;
  ad_outcome_e outcome;
  ad_ftype_e   ftype;

  assign start = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pte_q    <= '0;
      addr_q   <= '0;
      gstage_q <= 1'b0;
      wr_q     <= 1'b0;
      ex_q     <= 1'b0;
      imp_q    <= 1'b0;
      fs_en_q  <= 1'b0;
      gs_en_q  <= 1'b0;
      gs_w_q   <= 1'b0;
    end else if (start) begin
      pte_q    <= req_pte_i;
      addr_q   <= req_addr_i;
      gstage_q <= req_gstage_i;
      wr_q     <= acc_write_i;
      ex_q     <= acc_exec_i;
      imp_q    <= acc_implicit_i;
      fs_en_q  <= fs_upd_en_i;
      gs_en_q  <= gs_upd_en_i;
      gs_w_q   <= gs_pte_w_i;
    end
  end

  ad_decide i_decide (
    .gstage_i  (gstage_q),
    .a_i       (pte_q[A_BIT]),
    .d_i       (pte_q[D_BIT]),
    .w_i       (pte_q[W_BIT]),
    .wr_i      (wr_q),
    .ex_i      (ex_q),
    .imp_i     (imp_q),
    .fs_en_i   (fs_en_q),
    .gs_en_i   (gs_en_q),
    .gs_w_i    (gs_w_q),
    .outcome_o (outcome),
    .set_d_o   (set_d),
    .ftype_o   (ftype)
  );

  ad_pte_patch #(.PTE_W(PTE_W), .A_BIT(A_BIT), .D_BIT(D_BIT)) i_patch (
    .pte_i   (pte_q),
    .set_d_i (set_d),
    .pte_o   (mem_wdata_o)
  );

  ad_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .outcome_i   (outcome),
    .mem_ready_i (mem_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_match_i (mem_rsp_match_i),
    .rsp_err_i   (mem_rsp_err_i),
    .idle_o      (req_ready_o),
    .mem_valid_o (mem_valid_o),
    .done_o      (done_o),
    .retry_o     (retry_o),
    .pf_o        (pf_o),
    .gpf_o       (gpf_o),
    .af_o        (af_o)
  );

  assign mem_addr_o = addr_q;
  assign mem_cmp_o  = pte_q;
  assign flt_type_o = ftype;
endmodule

// File: rtl/ad_updater_chk.sv
module ad_updater_chk #(
  parameter int PTE_W = 64,
  parameter int A_BIT = 6,
  parameter int D_BIT = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             mem_valid_o,
  input logic             mem_ready_i,
  input logic [PTE_W-1:0] mem_cmp_o,
  input logic [PTE_W-1:0] mem_wdata_o,
  input logic             mem_rsp_valid_i,
  input logic             mem_rsp_match_i,
  input logic             mem_rsp_err_i,
  input logic             done_o,
  input logic             retry_o,
  input logic             pf_o,
  input logic             gpf_o,
  input logic             af_o
);
  localparam logic [PTE_W-1:0] AD_MASK = (PTE_W'(1) << A_BIT) | (PTE_W'(1) << D_BIT);
  logic [4:0] pulses;
  assign pulses = {done_o, retry_o, pf_o, gpf_o, af_o};

  // R11
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pulses) <= 1);
  // R11
  short_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulses != 5'd0) |=> (pulses == 5'd0));
  // R13
  busy_while_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);
  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_wdata_o)));
  // R8
  swap_a_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_wdata_o[A_BIT]);
  // R8
  swap_only_ad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (((mem_wdata_o ^ mem_cmp_o) & ~AD_MASK) == '0));
  // R9
  af_from_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    af_o |-> $past(mem_rsp_valid_i && mem_rsp_err_i));
  // R10
  retry_from_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> $past(mem_rsp_valid_i && !mem_rsp_err_i && !mem_rsp_match_i));
endmodule

bind ad_updater ad_updater_chk #(.PTE_W(PTE_W), .A_BIT(A_BIT), .D_BIT(D_BIT)) i_chk (.*);

// File: tb/test_ad_updater.sv
module test_ad_updater;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int AW = 12;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [PW-1:0] req_pte = '0;
  logic [AW-1:0] req_addr = '0;
  logic gstage = 1'b0, wr = 1'b0, ex = 1'b0, imp = 1'b0;
  logic fs_en = 1'b0, gs_en = 1'b0, gs_w = 1'b0;
  logic mem_valid, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_cmp, mem_wdata;
  logic rsp_valid = 1'b0, rsp_match = 1'b0, rsp_err = 1'b0;
  logic done, retry, pf, gpf, af;
  logic [1:0] ftype;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ad_updater #(.PTE_W(PW), .ADDR_W(AW)) i_ad_updater (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_pte_i(req_pte), .req_addr_i(req_addr), .req_gstage_i(gstage),
    .acc_write_i(wr), .acc_exec_i(ex), .acc_implicit_i(imp),
    .fs_upd_en_i(fs_en), .gs_upd_en_i(gs_en), .gs_pte_w_i(gs_w),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_cmp_o(mem_cmp), .mem_wdata_o(mem_wdata),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_match_i(rsp_match), .mem_rsp_err_i(rsp_err),
    .done_o(done), .retry_o(retry), .pf_o(pf), .gpf_o(gpf), .af_o(af),
    .flt_type_o(ftype)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // result vector {af,gpf,pf,retry,done}
  task automatic run_case(input int idx);
    bit a, d, w, upd, need, fd, issued, sent;
    int acc;
    logic [4:0] exp_res, got;
    logic [PW-1:0] exp_w;
    logic [1:0] exp_ft;
    a = idx[0]; d = idx[1]; w = idx[2];
    acc = (idx >> 3) & 3;
    @(negedge clk);
    gstage = idx[5]; fs_en = idx[6]; gs_en = idx[7]; gs_w = idx[8];
    wr = (acc == 1); ex = (acc == 2); imp = (acc == 3);
    req_pte = PW'({idx[7:0], 8'h00}) | PW'({d, a, 3'b000, w, 2'b01});
    req_addr = AW'(idx * 7);
    req_valid = 1'b1;
    exp_ft = ex ? 2'd2 : (wr ? 2'd1 : 2'd0);
    upd = 1'b0; fd = 1'b0; exp_res = 5'b00001;
    if (gstage) begin
      fd = imp && !d && w && fs_en && gs_en;
      need = !a || (wr && !d) || fd;
      if (need && !gs_en) exp_res = 5'b01000;
      else if (need) upd = 1'b1;
    end else begin
      need = !a || (wr && !d && w);
      if (need && !gs_w) exp_res = 5'b01000;
      else if (need && !fs_en) exp_res = 5'b00100;
      else if (need) upd = 1'b1;
    end
    exp_w = req_pte | (PW'(1) << 6) | ((wr || fd) ? (PW'(1) << 7) : '0);
    if (upd) case (idx % 3)
      0: exp_res = 5'b00001;
      1: exp_res = 5'b00010;
      default: exp_res = 5'b10000;
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    // R13
    check(req_ready == 1'b0, "R13 busy after accept", req_ready, 0);
    issued = 0; sent = 0; got = '0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      got = {af, gpf, pf, retry, done};
      if (got != 0) break;
      if (mem_valid && !issued) begin
        issued = 1;
        // R8
        check(mem_wdata == exp_w, "R8 swap value", mem_wdata, exp_w);
        check(mem_cmp == req_pte && mem_addr == req_addr, "R8 compare value/address", mem_cmp, req_pte);
        // R13
        check(req_ready == 1'b0, "R13 busy during mem", req_ready, 0);
        mem_ready = 1'b1;
      end else if (issued && !sent) begin
        sent = 1;
        mem_ready = 1'b0;
        rsp_valid = 1'b1;
        rsp_match = (idx % 3) != 1;
        rsp_err = (idx % 3) == 2;
      end else begin
        rsp_valid = 1'b0;
        rsp_match = 1'b0;
        rsp_err = 1'b0;
      end
    end
    rsp_valid = 1'b0; rsp_match = 1'b0; rsp_err = 1'b0; mem_ready = 1'b0;
    // R2 R3 R4 R5 R6 R7 R9 R10: outcome per decision rules
    check(got == exp_res, gstage ? "R2/R3/R4/R9/R10 G-stage outcome" : "R5/R6/R7/R9/R10 first-stage outcome",
          got, exp_res);
    check(issued == upd, "R2 R5 memory access only on update", issued, upd);
    if (got[4] | got[3] | got[2])
      check(ftype == exp_ft, "R12 fault type", ftype, exp_ft);
    @(negedge clk);
    // R11
    check({af, gpf, pf, retry, done} == 5'd0 && req_ready, "R11 single pulse", {af, gpf, pf, retry, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(mem_valid == 1'b0, "R1 mem idle in reset", mem_valid, 0);
    check({af, gpf, pf, retry, done} == 5'd0, "R1 pulses low in reset", {af, gpf, pf, retry, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 512; i++) begin
      if (i[4:3] == 2'b11 && i[0] && !i[1] && i[2]) begin
        // R3: implicit, A=1, D=0, W=1 exercised here within the sweep
      end
      run_case(i);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule